// File: doc/BRIEF.md
# GPIO Port with Interrupt Sensing

This block is a 32-pin general-purpose I/O port with a small 32-bit memory-mapped register file. Software picks, for each pin, whether it is an output, what value it drives, and how it raises an interrupt request: low level, high level, rising edge or falling edge.

Pin inputs pass through a two-flop synchroniser before any logic uses them. A per-pin detector feeds a status register that software clears by writing ones. Edge events stay latched until they are cleared. A level condition that is still present sets its bit again on the next cycle. A mask register decides which status bits reach the single interrupt line, and masked bits still latch. Register reads are combinational and appear in the same cycle as the read strobe.

Top module: `gpio_sense_port`

## Requirements
- R1: After reset, the direction, mask, both configuration and output-value registers read zero, and `irq` is low.
- R2: `pin_out` carries the output-value register and `pin_oe` carries the direction register, where a 1 makes the pin an output. Both are written at byte offsets 0x00 and 0x04.
- R3: A read at 0x00 returns, for each bit, the output value where the direction bit is 1 and the synchronised pin where it is 0. A read at 0x08 returns the synchronised pins. A pin change shows up in reads within four cycles.
- R4: Each pin has a 2-bit sense field: 00 low level, 01 high level, 10 rising edge, 11 falling edge. Pins 0 to 15 sit at 0x0C and pins 16 to 31 sit at 0x10, each at bit 2*(pin mod 16). Both registers read back what was written.
- R5: While a level-sensed pin is at its active level, its status bit is set. Clearing it while the level persists leaves it set. Once the level goes away, a clear sticks.
- R6: On an edge-sensed pin, the matching transition sets the status bit, and the bit stays set after the pin returns to idle, until software clears it.
- R7: The status register sits at 0x18. Writing 1 to a bit clears it and writing 0 leaves it unchanged. If a hardware set and a clear hit the same bit in the same cycle, the set wins.
- R8: The mask register sits at 0x14. `irq` is the OR over all pins of status AND mask. Status bits keep latching while their mask bit is 0.
- R9: Reads of unmapped or unaligned addresses return zero, and `rd_data` is zero whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (8) | Register byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data (combinational) |
| pin_in | input | PINS (32) | Asynchronous pin inputs |
| pin_out | output | PINS (32) | Pin drive values |
| pin_oe | output | PINS (32) | Pin output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bound checker watches four rules on every cycle:
- any active level condition is reflected in status by the next cycle;
- a status bit never drops without a write to the status register;
- the interrupt stays low under an all-zero mask;
- `pin_oe` and `rd_data` follow only their own writes and strobes.

Only the bench's scenarios can show other behaviour. This covers the placement of each field in the split configuration registers, the hold of an edge event after the pin returns to idle, the mixed data read path and the exact clear behaviour. It does so against a model that tracks pins, modes and writes.

// File: rtl/gpio_sense_pkg.sv
package gpio_sense_pkg;

    localparam int PORT_PINS = 32;
    localparam int BUS_W     = 32;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_HIGH = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_FALL = 2'b11
    } sense_e;

    typedef enum logic [2:0] {
        SEL_DATA,
        SEL_DIR,
        SEL_PAD,
        SEL_CFG_LO,
        SEL_CFG_HI,
        SEL_MASK,
        SEL_STAT,
        SEL_NONE
    } reg_sel_e;

    // Byte offsets of the register file
    localparam logic [7:0] OFS_DATA   = 8'h00;
    localparam logic [7:0] OFS_DIR    = 8'h04;
    localparam logic [7:0] OFS_PAD    = 8'h08;
    localparam logic [7:0] OFS_CFG_LO = 8'h0C;
    localparam logic [7:0] OFS_CFG_HI = 8'h10;
    localparam logic [7:0] OFS_MASK   = 8'h14;
    localparam logic [7:0] OFS_STAT   = 8'h18;

    function automatic reg_sel_e decode_sel(input logic [7:0] ofs, input logic upper_zero);
        reg_sel_e s;
        if (!upper_zero) s = SEL_NONE;
        else begin
            case (ofs)
                OFS_DATA:   s = SEL_DATA;
                OFS_DIR:    s = SEL_DIR;
                OFS_PAD:    s = SEL_PAD;
                OFS_CFG_LO: s = SEL_CFG_LO;
                OFS_CFG_HI: s = SEL_CFG_HI;
                OFS_MASK:   s = SEL_MASK;
                OFS_STAT:   s = SEL_STAT;
                default:    s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

    function automatic logic sense_hit(input sense_e m, input logic cur, input logic prev);
        logic h;
        case (m)
            SENSE_LOW:  h = !cur;
            SENSE_HIGH: h = cur;
            SENSE_RISE: h = cur && !prev;
            default:    h = !cur && prev;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            cur  <= '0;
            prev <= '0;
        end else begin
            meta <= raw;
            cur  <= meta;
            prev <= cur;
        end
    end
endmodule

// File: rtl/gpio_sense_detect.sv
module gpio_sense_detect
    import gpio_sense_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2*W-1:0] cfg,
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   prev,
    output logic [W-1:0]   hit
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            hit[i] = sense_hit(sense_e'(cfg[2*i +: 2]), cur[i], prev[i]);
        end
    end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] hit,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] status
);
    logic [W-1:0] clr_eff;

    always_comb clr_eff = clr_en ? clr_bits : '0;

    // hardware set takes priority over a software clear
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_eff) | hit;
    end
endmodule

// File: rtl/gpio_sense_port.sv
module gpio_sense_port
    import gpio_sense_pkg::*;
#(
    parameter int PINS   = PORT_PINS,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              rd_en,
    output logic [BUS_W-1:0]  rd_data,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq
);
    localparam int CFG_W  = 2 * PINS;
    localparam int HALF_W = CFG_W / 2;

    logic [PINS-1:0]  out_q, dir_q, mask_q, stat_q;
    logic [CFG_W-1:0] cfg_q;
    logic [PINS-1:0]  sync_cur, sync_prev, hit;
    logic             upper_zero;
    reg_sel_e         sel;

    always_comb begin
        if (ADDR_W > 8) upper_zero = ((addr >> 8) == '0);
        else            upper_zero = 1'b1;
        sel = decode_sel(addr[7:0], upper_zero);
    end

    gpio_pin_sync #(.W(PINS)) u_sync (
        .clk (clk), .rst (rst), .raw (pin_in),
        .cur (sync_cur), .prev (sync_prev)
    );

    gpio_sense_detect #(.W(PINS)) u_detect (
        .cfg (cfg_q), .cur (sync_cur), .prev (sync_prev), .hit (hit)
    );

    gpio_irq_status #(.W(PINS)) u_status (
        .clk (clk), .rst (rst), .hit (hit),
        .clr_en   (wr_en && sel == SEL_STAT),
        .clr_bits (wr_data[PINS-1:0]),
        .status   (stat_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            dir_q  <= '0;
            mask_q <= '0;
            cfg_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DATA:   out_q  <= wr_data[PINS-1:0];
                SEL_DIR:    dir_q  <= wr_data[PINS-1:0];
                SEL_MASK:   mask_q <= wr_data[PINS-1:0];
                SEL_CFG_LO: cfg_q[HALF_W-1:0]     <= wr_data[HALF_W-1:0];
                SEL_CFG_HI: cfg_q[CFG_W-1:HALF_W] <= wr_data[HALF_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (sel)
                SEL_DATA:   rd_data[PINS-1:0]   = (dir_q & out_q) | (~dir_q & sync_cur);
                SEL_DIR:    rd_data[PINS-1:0]   = dir_q;
                SEL_PAD:    rd_data[PINS-1:0]   = sync_cur;
                SEL_CFG_LO: rd_data[HALF_W-1:0] = cfg_q[HALF_W-1:0];
                SEL_CFG_HI: rd_data[HALF_W-1:0] = cfg_q[CFG_W-1:HALF_W];
                SEL_MASK:   rd_data[PINS-1:0]   = mask_q;
                SEL_STAT:   rd_data[PINS-1:0]   = stat_q;
                default:    rd_data = '0;
            endcase
        end
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq     = |(stat_q & mask_q);
endmodule

// File: rtl/gpio_sense_port_chk.sv
module gpio_sense_port_chk
    import gpio_sense_pkg::*;
#(
    parameter int PINS   = PORT_PINS,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [BUS_W-1:0]  rd_data,
    input logic [PINS-1:0]   pin_oe,
    input logic              irq,
    input logic [PINS-1:0]   stat_q,
    input logic [PINS-1:0]   mask_q,
    input logic [2*PINS-1:0] cfg_q,
    input logic [PINS-1:0]   sync_cur
);
    logic [PINS-1:0] lvl_active;
    logic            wr_stat, wr_dir;

    for (genvar i = 0; i < PINS; i++) begin : g_lvl
        always_comb lvl_active[i] =
            (cfg_q[2*i +: 2] == 2'b00 && !sync_cur[i]) ||
            (cfg_q[2*i +: 2] == 2'b01 &&  sync_cur[i]);
    end

    always_comb begin
        wr_stat = wr_en && (addr == ADDR_W'(OFS_STAT));
        wr_dir  = wr_en && (addr == ADDR_W'(OFS_DIR));
    end

    // R5: an active level is in status one cycle later
    p_level_sets_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(lvl_active) & ~stat_q) == '0));

    // R6 / R7: status bits only drop after a status write
    p_sticky_status_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_stat)) |-> (($past(stat_q) & ~stat_q) == '0));

    // R8: nothing reaches irq with an all-zero mask
    p_mask_gates_r8: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq);

    // R2: pin_oe changes only after a direction write
    p_oe_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_dir)) |-> $stable(pin_oe));

    // R9: idle read bus
    p_rd_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == '0));
endmodule

bind gpio_sense_port gpio_sense_port_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk (clk), .rst (rst), .addr (addr), .wr_en (wr_en), .rd_en (rd_en),
    .rd_data (rd_data), .pin_oe (pin_oe), .irq (irq), .stat_q (stat_q),
    .mask_q (mask_q), .cfg_q (cfg_q), .sync_cur (sync_cur)
);

// File: tb/gpio_sense_port_tb_top.sv
module gpio_sense_port_tb_top;
    logic        clk = 0;
    logic        rst;
    logic [7:0]  addr;
    logic        wr_en, rd_en;
    logic [31:0] wr_data, rd_data;
    logic [31:0] pin_in, pin_out, pin_oe;
    logic        irq;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    logic [31:0] e_out, e_dir, e_mask, e_stat, e_pins;
    logic [63:0] e_cfg;

    always #2 clk = ~clk;

    gpio_sense_port dut_i (
        .clk (clk), .rst (rst), .addr (addr), .wr_en (wr_en), .wr_data (wr_data),
        .rd_en (rd_en), .rd_data (rd_data), .pin_in (pin_in), .pin_out (pin_out),
        .pin_oe (pin_oe), .irq (irq)
    );

    function automatic logic [31:0] lvl_of(input logic [63:0] cfg, input logic [31:0] p);
        logic [31:0] r;
        for (int i = 0; i < 32; i++)
            r[i] = (cfg[2*i +: 2] == 2'b00 && !p[i]) || (cfg[2*i +: 2] == 2'b01 && p[i]);
        return r;
    endfunction

    function automatic logic [31:0] edge_of(input logic [63:0] cfg, input logic [31:0] o, input logic [31:0] n);
        logic [31:0] r;
        for (int i = 0; i < 32; i++)
            r[i] = (cfg[2*i +: 2] == 2'b10 && !o[i] && n[i]) || (cfg[2*i +: 2] == 2'b11 && o[i] && !n[i]);
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
        e_stat |= lvl_of(e_cfg, e_pins);
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
        case (a)
            8'h00: e_out  = d;
            8'h04: e_dir  = d;
            8'h0C: e_cfg[31:0]  = d;
            8'h10: e_cfg[63:32] = d;
            8'h14: e_mask = d;
            8'h18: e_stat &= ~d;
            default: ;
        endcase
        settle();
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1;
        #1 d = rd_data;
        rd_en = 0;
    endtask

    task automatic drive_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        e_stat |= edge_of(e_cfg, e_pins, v);
        e_pins = v;
        settle();
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        reg_rd(a, d);
        check(tag, d, exp);
    endtask

    task automatic irq_check(input string tag);
        @(negedge clk);
        check(tag, {31'd0, irq}, {31'd0, |(e_stat & e_mask)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed);
        rst = 1; addr = 0; wr_en = 0; rd_en = 0; wr_data = 0; pin_in = 0;
        e_out = 0; e_dir = 0; e_mask = 0; e_stat = 0; e_pins = 0; e_cfg = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        // R1: reset state
        rd_check("R1 dir", 8'h04, 0);
        rd_check("R1 mask", 8'h14, 0);
        rd_check("R1 cfg lo", 8'h0C, 0);
        rd_check("R1 cfg hi", 8'h10, 0);
        check("R1 pin_out", pin_out, 0);
        check("R1 irq", {31'd0, irq}, 0);
        settle();
        // R5: default low-level mode with low pins sets every bit
        rd_check("R5 reset-level status", 8'h18, e_stat);

        // R2 / R3: outputs and data read mix
        reg_wr(8'h00, 32'hA5A5_0F0F);
        reg_wr(8'h04, 32'hFFFF_0000);
        drive_pins(32'h1234_5678);
        check("R2 pin_out", pin_out, 32'hA5A5_0F0F);
        check("R2 pin_oe", pin_oe, 32'hFFFF_0000);
        rd_check("R3 data mix", 8'h00, 32'hA5A5_5678);
        rd_check("R3 pad", 8'h08, 32'h1234_5678);

        // R4: field placement, pin 3 rising, pin 20 falling, pin 5 high level
        drive_pins(32'h0);
        reg_wr(8'h0C, 32'h0000_0480 | 32'h0);
        reg_wr(8'h10, 32'h0000_0300);
        rd_check("R4 cfg lo", 8'h0C, 32'h0000_0480);
        rd_check("R4 cfg hi", 8'h10, 32'h0000_0300);
        reg_wr(8'h18, 32'hFFFF_FFFF);
        // pins 3, 5 and 20 are now not level-active at 0; others low-level still set
        rd_check("R7 clear all", 8'h18, e_stat);
        check("R7 bits 3/5/20 clear", e_stat & 32'h0010_0028, 0);

        // R6: rising edge latches and holds
        drive_pins(32'h0000_0008);
        drive_pins(32'h0);
        rd_check("R6 rise held", 8'h18, e_stat);
        check("R6 model bit3", {31'd0, e_stat[3]}, 1);
        // R6: falling edge on pin 20
        drive_pins(32'h0010_0000);
        reg_wr(8'h18, 32'h0010_0000);
        rd_check("R6 no fall yet", 8'h18, e_stat);
        drive_pins(32'h0);
        rd_check("R6 fall held", 8'h18, e_stat);

        // R5: high level on pin 5 re-asserts after clear
        drive_pins(32'h0000_0020);
        reg_wr(8'h18, 32'h0000_0020);
        rd_check("R5 level reasserts", 8'h18, e_stat);
        drive_pins(32'h0);
        reg_wr(8'h18, 32'h0000_0020);
        rd_check("R5 clear sticks", 8'h18, e_stat);

        // R7: writing zero has no effect
        reg_wr(8'h18, 32'h0);
        rd_check("R7 zero write", 8'h18, e_stat);

        // R8: mask gating, latch while masked
        reg_wr(8'h14, 32'h0000_0000);
        drive_pins(32'h0000_0008);
        irq_check("R8 masked irq low");
        rd_check("R8 latched while masked", 8'h18, e_stat);
        reg_wr(8'h14, 32'h0000_0008);
        irq_check("R8 irq high");

        // R9: unmapped and unaligned
        rd_check("R9 unmapped", 8'h1C, 0);
        rd_check("R9 unaligned", 8'h02, 0);
        @(negedge clk);
        check("R9 idle bus", rd_data, 0);

        // randomised mix
        for (int k = 0; k < 150; k++) begin
            int op;
            op = $urandom_range(0, 5);
            case (op)
                0: drive_pins($urandom);
                1: reg_wr(8'h0C, $urandom);
                2: reg_wr(8'h10, $urandom);
                3: reg_wr(8'h14, $urandom);
                4: reg_wr(8'h18, $urandom);
                default: begin reg_wr(8'h00, $urandom); reg_wr(8'h04, $urandom); end
            endcase
            rd_check("R7 random status", 8'h18, e_stat);
            irq_check("R8 random irq");
            if (k % 10 == 0) begin
                rd_check("R3 random data", 8'h00, (e_dir & e_out) | (~e_dir & e_pins));
                rd_check("R4 random cfg hi", 8'h10, e_cfg[63:32]);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule